// File: doc/BRIEF.md
# Mode-Configurable Twin-Bank Bit RAM

This block is a small on-chip memory made of two 16-entry, 1-bit storage banks. A static mode input chooses how the banks appear at the ports. They can act as two independent 16x1 RAMs, as one 32x1 RAM, or as a 16x1 RAM with one write port and two read ports. All writes happen on the rising clock edge, and the write enable gates that edge. Reads are purely combinational in every mode.

A synchronous clear input sets every cell to zero. After power-up the contents are undefined until the cells are cleared or written. The mode is meant to be held static. Changing it remaps the ports but does not touch the stored bits.

Top module: `lutram_cell`

## Requirements
- R1: When `init_i` is high at a rising clock edge, every cell of both banks becomes 0. This takes priority over any write in that cycle.
- R2: A cell changes only at a rising clock edge with `we_i` high (or `init_i` high). When `we_i` and `init_i` are both low at an edge, no cell in either bank changes.
- R3: Split mode (`mode_i` = 2'd0) works as two separate RAMs. Bank A is written at `addr_a_i` with `din_a_i` and read on `dout_a_o` at `addr_a_i`. Bank B is written at `addr_b_i` with `din_b_i` and read on `dout_b_o` at `addr_b_i`. Equal or different addresses are both legal.
- R4: Wide mode (`mode_i` = 2'd1) forms one 32-cell RAM. `addr_hi_i` selects the bank (0 = bank A, 1 = bank B), and `addr_a_i` selects the cell within it. The write data comes from `din_a_i`, and the read appears on `dout_a_o`. `dout_b_o` is 0, and `din_b_i` and `addr_b_i` have no effect.
- R5: Dual-port mode (`mode_i` = 2'd2) writes `din_a_i` at `addr_a_i` into both banks. `dout_a_o` reads bank A at `addr_a_i`, and `dout_b_o` reads bank B at `addr_b_i`.
- R6: Reads are combinational. When a read hits the cell being written in the same cycle, it shows the old value before the edge and the new value after it.
- R7: Changing `mode_i` leaves all stored bits unchanged and only changes how ports map onto the banks.
- R8: Mode 2'd3 is reserved. In that mode nothing is written and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, rising edge |
| init_i | input | 1 | Synchronous clear of all cells |
| mode_i | input | 2 | Arrangement select: 0 split, 1 wide, 2 dual-port, 3 reserved |
| we_i | input | 1 | Write enable for the coming edge |
| addr_a_i | input | 4 | Port A address |
| addr_b_i | input | 4 | Port B address |
| addr_hi_i | input | 1 | Bank select in wide mode |
| din_a_i | input | 1 | Port A write data |
| din_b_i | input | 1 | Port B write data (split mode only) |
| dout_a_o | output | 1 | Port A read data |
| dout_b_o | output | 1 | Port B read data |

## Verification
The bench targets a read of the very cell being written, sampled just before the edge. A design with a write-through bypass would show the new bit one cycle early.

In wide mode, the bench fills all 32 cells with a pattern in which the two banks differ. A design that swapped the meaning of the bank select, or ignored it, would return the other bank's bit.

Dual-port writes are followed by reads of bank B at an independent address. A design that wrote only bank A would return stale bits on the second port.

Finally, the bench switches mode after writing and uses reserved-mode cycles with the write enable held high. A design that reset or disturbed its contents on a mode change, or wrote in the reserved mode, would show wrong bits at the next read.

// File: rtl/lutram_pkg.sv
package lutram_pkg;
   typedef enum logic [1:0] {
      MODE_SPLIT = 2'd0,
      MODE_WIDE  = 2'd1,
      MODE_DPORT = 2'd2,
      MODE_RSVD  = 2'd3
   } lutram_mode_t;

   localparam int unsigned NUM_BANKS = 2;
   localparam int unsigned BANK_A    = 0;
   localparam int unsigned BANK_B    = 1;
endpackage

// File: rtl/lutram_bank.sv
module lutram_bank #(
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              clr_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic              wdata_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic              rdata_o
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_width
      $error("lutram_bank: ADDR_W must be 1..8");
   end

   logic [DEPTH-1:0] cells;

   always_ff @(posedge clk) begin
      if (clr_i) begin
         cells <= '0;
      end else if (we_i) begin
         cells[waddr_i] <= wdata_i;
      end
   end

   assign rdata_o = cells[raddr_i];

   logic armed;
   always_ff @(posedge clk) armed <= 1'b1;

   // R1
   clear_all_chk: assert property (@(posedge clk) disable iff (!armed)
      clr_i |=> (cells == '0));

   // R2
   write_lands_chk: assert property (@(posedge clk) disable iff (!armed)
      (we_i && !clr_i) |=> (cells[$past(waddr_i)] == $past(wdata_i)));

   // R2
   hold_idle_chk: assert property (@(posedge clk) disable iff (!armed)
      (!we_i && !clr_i) |=> $stable(cells));
endmodule

// File: rtl/lutram_steer.sv
module lutram_steer
   import lutram_pkg::*;
#(
   parameter int unsigned ADDR_W = 4
) (
   input  lutram_mode_t                       mode_i,
   input  logic                               we_i,
   input  logic [ADDR_W-1:0]                  addr_a_i,
   input  logic [ADDR_W-1:0]                  addr_b_i,
   input  logic                               addr_hi_i,
   input  logic                               din_a_i,
   input  logic                               din_b_i,
   input  logic [NUM_BANKS-1:0]               bank_rdata_i,
   output logic [NUM_BANKS-1:0]               bank_we_o,
   output logic [NUM_BANKS-1:0][ADDR_W-1:0]   bank_waddr_o,
   output logic [NUM_BANKS-1:0]               bank_wdata_o,
   output logic [NUM_BANKS-1:0][ADDR_W-1:0]   bank_raddr_o,
   output logic                               dout_a_o,
   output logic                               dout_b_o
);
   always_comb begin
      bank_we_o    = '0;
      bank_waddr_o = '0;
      bank_wdata_o = '0;
      bank_raddr_o = '0;
      unique case (mode_i)
         MODE_SPLIT: begin
            bank_we_o[BANK_A]    = we_i;
            bank_we_o[BANK_B]    = we_i;
            bank_waddr_o[BANK_A] = addr_a_i;
            bank_waddr_o[BANK_B] = addr_b_i;
            bank_wdata_o[BANK_A] = din_a_i;
            bank_wdata_o[BANK_B] = din_b_i;
            bank_raddr_o[BANK_A] = addr_a_i;
            bank_raddr_o[BANK_B] = addr_b_i;
         end
         MODE_WIDE: begin
            bank_we_o[BANK_A]    = we_i && !addr_hi_i;
            bank_we_o[BANK_B]    = we_i &&  addr_hi_i;
            bank_waddr_o[BANK_A] = addr_a_i;
            bank_waddr_o[BANK_B] = addr_a_i;
            bank_wdata_o[BANK_A] = din_a_i;
            bank_wdata_o[BANK_B] = din_a_i;
            bank_raddr_o[BANK_A] = addr_a_i;
            bank_raddr_o[BANK_B] = addr_a_i;
         end
         MODE_DPORT: begin
            bank_we_o[BANK_A]    = we_i;
            bank_we_o[BANK_B]    = we_i;
            bank_waddr_o[BANK_A] = addr_a_i;
            bank_waddr_o[BANK_B] = addr_a_i;
            bank_wdata_o[BANK_A] = din_a_i;
            bank_wdata_o[BANK_B] = din_a_i;
            bank_raddr_o[BANK_A] = addr_a_i;
            bank_raddr_o[BANK_B] = addr_b_i;
         end
         default: begin
         end
      endcase
   end

   always_comb begin
      dout_a_o = 1'b0;
      dout_b_o = 1'b0;
      unique case (mode_i)
         MODE_SPLIT, MODE_DPORT: begin
            dout_a_o = bank_rdata_i[BANK_A];
            dout_b_o = bank_rdata_i[BANK_B];
         end
         MODE_WIDE: begin
            dout_a_o = addr_hi_i ? bank_rdata_i[BANK_B] : bank_rdata_i[BANK_A];
         end
         default: begin
         end
      endcase
   end
endmodule

// File: rtl/lutram_cell.sv
module lutram_cell
   import lutram_pkg::*;
#(
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              init_i,
   input  logic [1:0]        mode_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_a_i,
   input  logic [ADDR_W-1:0] addr_b_i,
   input  logic              addr_hi_i,
   input  logic              din_a_i,
   input  logic              din_b_i,
   output logic              dout_a_o,
   output logic              dout_b_o
);
   if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_width
      $error("lutram_cell: ADDR_W must be 1..8");
   end

   lutram_mode_t mode;
   assign mode = lutram_mode_t'(mode_i);

   logic [NUM_BANKS-1:0]             bank_we;
   logic [NUM_BANKS-1:0][ADDR_W-1:0] bank_waddr;
   logic [NUM_BANKS-1:0]             bank_wdata;
   logic [NUM_BANKS-1:0][ADDR_W-1:0] bank_raddr;
   logic [NUM_BANKS-1:0]             bank_rdata;

   lutram_steer #(.ADDR_W(ADDR_W)) u_steer (
      .mode_i       (mode),
      .we_i         (we_i),
      .addr_a_i     (addr_a_i),
      .addr_b_i     (addr_b_i),
      .addr_hi_i    (addr_hi_i),
      .din_a_i      (din_a_i),
      .din_b_i      (din_b_i),
      .bank_rdata_i (bank_rdata),
      .bank_we_o    (bank_we),
      .bank_waddr_o (bank_waddr),
      .bank_wdata_o (bank_wdata),
      .bank_raddr_o (bank_raddr),
      .dout_a_o     (dout_a_o),
      .dout_b_o     (dout_b_o)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      lutram_bank #(.ADDR_W(ADDR_W)) u_bank (
         .clk     (clk),
         .clr_i   (init_i),
         .we_i    (bank_we[b]),
         .waddr_i (bank_waddr[b]),
         .wdata_i (bank_wdata[b]),
         .raddr_i (bank_raddr[b]),
         .rdata_o (bank_rdata[b])
      );
   end

   // R4
   wide_quiet_chk: assert property (@(posedge clk) disable iff (init_i)
      (mode == MODE_WIDE) |-> (dout_b_o == 1'b0));

   // R4
   wide_onebank_chk: assert property (@(posedge clk) disable iff (init_i)
      (mode == MODE_WIDE) |-> ($countones(bank_we) <= 1));

   // R5
   dport_both_chk: assert property (@(posedge clk) disable iff (init_i)
      (mode == MODE_DPORT && we_i) |-> (bank_we == '1));

   // R8
   rsvd_nowrite_chk: assert property (@(posedge clk) disable iff (init_i)
      (mode == MODE_RSVD) |-> (bank_we == '0 && dout_a_o == 1'b0 && dout_b_o == 1'b0));
endmodule

// File: tb/test_lutram_cell.sv
module test_lutram_cell;
   logic       clk = 1'b0;
   logic       init_i = 1'b0;
   logic [1:0] mode_i = 2'd0;
   logic       we_i = 1'b0;
   logic [3:0] addr_a_i = '0;
   logic [3:0] addr_b_i = '0;
   logic       addr_hi_i = 1'b0;
   logic       din_a_i = 1'b0;
   logic       din_b_i = 1'b0;
   logic       dout_a_o, dout_b_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit ref_a[16];
   bit ref_b[16];

   always #5 clk = ~clk;

   lutram_cell i_lutram_cell (
      .clk(clk), .init_i(init_i), .mode_i(mode_i), .we_i(we_i),
      .addr_a_i(addr_a_i), .addr_b_i(addr_b_i), .addr_hi_i(addr_hi_i),
      .din_a_i(din_a_i), .din_b_i(din_b_i),
      .dout_a_o(dout_a_o), .dout_b_o(dout_b_o)
   );

   task automatic check(string req, bit act, bit exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0b expected %0b (mode %0d a %0d b %0d hi %0b)",
                  req, act, exp, mode_i, addr_a_i, addr_b_i, addr_hi_i);
      end
   endtask

   function automatic string mode_tag();
      case (mode_i)
         2'd0: return "R3";
         2'd1: return "R4";
         2'd2: return "R5";
         default: return "R8";
      endcase
   endfunction

   // compare outputs against model for the currently driven inputs
   task automatic compare(string req);
      bit ea, eb;
      case (mode_i)
         2'd0: begin ea = ref_a[addr_a_i]; eb = ref_b[addr_b_i]; end
         2'd1: begin ea = addr_hi_i ? ref_b[addr_a_i] : ref_a[addr_a_i]; eb = 1'b0; end
         2'd2: begin ea = ref_a[addr_a_i]; eb = ref_b[addr_b_i]; end
         default: begin ea = 1'b0; eb = 1'b0; end
      endcase
      check(req, dout_a_o, ea);
      check(req, dout_b_o, eb);
   endtask

   // apply model update for the edge that ends this cycle
   task automatic model_edge();
      if (init_i) begin
         for (int i = 0; i < 16; i++) begin ref_a[i] = 1'b0; ref_b[i] = 1'b0; end
      end else if (we_i) begin
         case (mode_i)
            2'd0: begin ref_a[addr_a_i] = din_a_i; ref_b[addr_b_i] = din_b_i; end
            2'd1: if (addr_hi_i) ref_b[addr_a_i] = din_a_i; else ref_a[addr_a_i] = din_a_i;
            2'd2: begin ref_a[addr_a_i] = din_a_i; ref_b[addr_a_i] = din_a_i; end
            default: ;
         endcase
      end
   endtask

   // one cycle: drive after falling edge, compare mid-phase, clock, update model
   task automatic cycle(input bit ini, input bit [1:0] md, input bit we,
                        input bit [3:0] aa, input bit [3:0] ab, input bit hi,
                        input bit da, input bit db, input string req);
      @(negedge clk);
      init_i = ini; mode_i = md; we_i = we; addr_a_i = aa; addr_b_i = ab;
      addr_hi_i = hi; din_a_i = da; din_b_i = db;
      #1;
      compare(req);
      @(posedge clk);
      model_edge();
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      // R1: clear, with a write requested in the same cycle
      @(negedge clk);
      init_i = 1'b1; we_i = 1'b1; mode_i = 2'd2; din_a_i = 1'b1;
      @(posedge clk);
      for (int i = 0; i < 16; i++) begin ref_a[i] = 1'b0; ref_b[i] = 1'b0; end
      for (int i = 0; i < 32; i++)
         cycle(0, 2'd1, 0, 4'(i), 4'(i), i[4], 0, 0, "R1");

      // R4: wide fill, banks differ (bit = parity of index and bank)
      for (int i = 0; i < 32; i++)
         cycle(0, 2'd1, 1, 4'(i), 4'(15 - (i % 16)), i[4], bit'(i[0] ^ i[4] ^ i[2]), 1, "R4");
      for (int i = 0; i < 32; i++)
         cycle(0, 2'd1, 0, 4'(i), 4'(i), i[4], 0, 0, "R4");

      // R7: switch to split mode, contents intact
      for (int i = 0; i < 16; i++)
         cycle(0, 2'd0, 0, 4'(i), 4'(15 - i), 0, 0, 0, "R7");

      // R3: split, shared address and different addresses
      for (int i = 0; i < 16; i++)
         cycle(0, 2'd0, 1, 4'(i), 4'(i), 0, i[0], !i[0], "R3");
      for (int i = 0; i < 16; i++)
         cycle(0, 2'd0, 1, 4'(i), 4'(i ^ 5), 0, i[1], i[2], "R3");
      for (int i = 0; i < 16; i++)
         cycle(0, 2'd0, 0, 4'(i), 4'(i), 0, 0, 0, "R3");

      // R6: same-cell read/write; compare() sees old value before the edge
      cycle(0, 2'd2, 1, 4'd6, 4'd6, 0, !ref_a[6], 0, "R6");
      cycle(0, 2'd2, 0, 4'd6, 4'd6, 0, 0, 0, "R6");
      cycle(0, 2'd2, 1, 4'd6, 4'd6, 0, !ref_a[6], 0, "R6");
      cycle(0, 2'd2, 0, 4'd6, 4'd6, 0, 0, 0, "R6");

      // R5: dual-port writes, independent second read address
      for (int i = 0; i < 16; i++)
         cycle(0, 2'd2, 1, 4'(i), 4'((i + 3) % 16), 0, bit'(i % 3 == 0), 0, "R5");
      for (int i = 0; i < 16; i++)
         cycle(0, 2'd2, 0, 4'(i), 4'((i * 7) % 16), 0, 0, 0, "R5");

      // R8: reserved mode with writes requested, then read back in split mode
      for (int i = 0; i < 16; i++)
         cycle(0, 2'd3, 1, 4'(i), 4'(i), i[0], !ref_a[i], !ref_b[i], "R8");
      for (int i = 0; i < 16; i++)
         cycle(0, 2'd0, 0, 4'(i), 4'(i), 0, 0, 0, "R8");

      // R2: idle cycles with changing data do not alter contents
      for (int i = 0; i < 32; i++)
         cycle(0, 2'd1, 0, 4'(i), 4'(i), i[4], 1, 1, "R2");
      for (int i = 0; i < 32; i++)
         cycle(0, 2'd1, 0, 4'(i), 4'(i), i[4], 0, 0, "R2");

      // random traffic over all modes, occasional clear (R1)
      for (int k = 0; k < 3000; k++) begin
         bit [1:0] md = 2'($urandom_range(0, 3));
         bit ini = ($urandom_range(0, 199) == 0);
         string tag;
         mode_i = md;
         tag = ini ? "R1" : mode_tag();
         cycle(ini, md, bit'($urandom_range(0, 1)), 4'($urandom), 4'($urandom),
               bit'($urandom), bit'($urandom), bit'($urandom), tag);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule